// File: doc/BRIEF.md
# Load/Store and Arithmetic Immediate Classifier

This block decides whether a 64-bit constant fits one of five compact immediate encodings used by load/store and arithmetic instructions. When it fits, the block produces the packed field bits. An instruction selector or code generator presents a candidate value with a strobe. It also gives a format code and an access-size bit that picks a 4-byte or an 8-byte scaling unit. One clock later the block returns a valid flag, an accept bit, an immediate field of up to 16 bits and a 2-bit shift code.

The five formats are:
- a signed 7-bit offset counted in access units
- a signed 9-bit byte offset
- an unsigned 12-bit offset counted in access units
- a 12-bit arithmetic immediate that may be shifted left by 12
- a 16-bit move-wide immediate placed in one of four halfwords

Each format has its own range test, alignment test and packing rule. A new candidate can be presented in every cycle.

Top module: `imm_classifier`

## Requirements
- R1: Format code 0 (scaled signed 7-bit) accepts a value v when v is a multiple of the unit u and -64*u <= v <= 63*u. The field is (v/u) in two's complement in out_imm[6:0], and out_shift is 0.
- R2: Format code 1 (signed 9-bit) accepts -256 <= v <= 255 with no alignment test. The field is the low 9 bits of v in out_imm[8:0], and out_shift is 0.
- R3: Format code 2 (scaled unsigned 12-bit) accepts a value v when v is a multiple of u and 0 <= v <= 4095*u. The field is v/u in out_imm[11:0], and out_shift is 0.
- R4: Format code 3 (arithmetic), treating v as unsigned: any v below 0xFFF, zero included, is accepted with out_imm[11:0]=v and out_shift=0. The value 0xFFF itself does not take this path.
- R5: Format code 3, otherwise: v is accepted when v < 0xFFF000 and v[11:0]==0. It is then packed as out_imm[11:0]=v>>12 with out_shift=1. All other values, including 0xFFF and 0xFFF000, are rejected.
- R6: Format code 4 (move-wide) accepts v when all of its set bits lie within one 16-bit halfword k (k=0 covers bits 15:0, up to k=3 for bits 63:48). The lowest such k is chosen, so zero gives k=0. out_imm is that halfword and out_shift is k.
- R7: in_size8=0 selects a 4-byte unit and in_size8=1 an 8-byte unit. Formats 0 and 2 reject a value that is not a multiple of the selected unit.
- R8: Format codes 5, 6 and 7 always give out_ok=0. Whenever out_ok is 0, out_imm and out_shift are 0.
- R9: out_valid is 1 exactly in the cycle after a cycle with in_valid=1. The result outputs change only in response to a strobe and hold their value through idle cycles.
- R10: A synchronous active-high reset drives out_valid, out_ok, out_imm and out_shift to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Candidate strobe |
| in_value | input | 64 | Candidate constant, two's complement |
| in_fmt | input | 3 | Format code 0..4, other codes reject |
| in_size8 | input | 1 | Access unit: 0 = 4 bytes, 1 = 8 bytes |
| out_valid | output | 1 | Result valid, one cycle after the strobe |
| out_ok | output | 1 | Candidate is encodable |
| out_imm | output | 16 | Packed immediate field, zero-extended |
| out_shift | output | 2 | Shift code (arithmetic: 0/1, move-wide: halfword 0..3) |

## Verification
The collision that matters is between capture and hold. In one cycle the output registers present the previous candidate's result while the next candidate is already on the inputs. In the following cycle the strobe may be absent, and the outputs must then hold their value. The bench drives strobes back to back and switches format and unit size from one cycle to the next, with idle gaps and a mid-run reset between them. A behavioural model predicts the outputs for every cycle, and the bench compares all outputs with it on every clock. Boundary values on both sides of each range are included: the edges of each format's range, misaligned offsets, 0xFFF and 0xFFF000, and values that span two halfwords.

// File: rtl/imm_pkg.sv
package imm_pkg;

    localparam int VAL_W = 64;
    localparam int IMM_W = 16;
    localparam int SH_W  = 2;

    typedef enum logic [2:0] {
        FMT_S7    = 3'd0,
        FMT_S9    = 3'd1,
        FMT_U12   = 3'd2,
        FMT_ARITH = 3'd3,
        FMT_MOVW  = 3'd4
    } fmt_e;

    typedef struct packed {
        logic             ok;
        logic [IMM_W-1:0] imm;
        logic [SH_W-1:0]  sh;
    } enc_t;

    function automatic enc_t enc_reject();
        enc_t e;
        e.ok  = 1'b0;
        e.imm = '0;
        e.sh  = '0;
        return e;
    endfunction

    function automatic enc_t enc_make(input logic ok, input logic [IMM_W-1:0] imm,
                                      input logic [SH_W-1:0] sh);
        enc_t e;
        e.ok  = ok;
        e.imm = ok ? imm : '0;
        e.sh  = ok ? sh  : '0;
        return e;
    endfunction

endpackage

// File: rtl/imm_offset_chk.sv
module imm_offset_chk
    import imm_pkg::*;
#(
    parameter int VAL_W_P = VAL_W,
    parameter int S7_W    = 7,
    parameter int S9_W    = 9,
    parameter int U12_W   = 12
) (
    input  logic [VAL_W_P-1:0] value,
    input  logic               size8,
    output enc_t               enc_s7,
    output enc_t               enc_s9,
    output enc_t               enc_u12
);
    localparam logic signed [VAL_W_P-1:0] S7_MAX  = VAL_W_P'((1 << (S7_W-1)) - 1);
    localparam logic signed [VAL_W_P-1:0] S7_MIN  = -(VAL_W_P'(1) << (S7_W-1));
    localparam logic signed [VAL_W_P-1:0] S9_MAX  = VAL_W_P'((1 << (S9_W-1)) - 1);
    localparam logic signed [VAL_W_P-1:0] S9_MIN  = -(VAL_W_P'(1) << (S9_W-1));
    localparam logic signed [VAL_W_P-1:0] U12_MAX = VAL_W_P'((1 << U12_W) - 1);

    logic signed [VAL_W_P-1:0] sval;
    logic signed [VAL_W_P-1:0] units;
    logic                      aligned;
    logic                      s7_fit;
    logic                      s9_fit;
    logic                      u12_fit;

    always_comb begin
        sval    = signed'(value);
        // unit count: exact for aligned values, arithmetic shift keeps the sign
        units   = size8 ? (sval >>> 3) : (sval >>> 2);
        aligned = size8 ? (value[2:0] == 3'b000) : (value[1:0] == 2'b00);
        s7_fit  = aligned && (units >= S7_MIN) && (units <= S7_MAX);
        s9_fit  = (sval >= S9_MIN) && (sval <= S9_MAX);
        u12_fit = aligned && (units >= 0) && (units <= U12_MAX);
    end

    assign enc_s7  = enc_make(s7_fit,  IMM_W'(units[S7_W-1:0]), '0);
    assign enc_s9  = enc_make(s9_fit,  IMM_W'(value[S9_W-1:0]), '0);
    assign enc_u12 = enc_make(u12_fit, IMM_W'(units[U12_W-1:0]), '0);

endmodule

// File: rtl/imm_arith_chk.sv
module imm_arith_chk
    import imm_pkg::*;
#(
    parameter int VAL_W_P = VAL_W,
    parameter int ARITH_W = 12
) (
    input  logic [VAL_W_P-1:0] value,
    output enc_t               enc
);
    localparam logic [VAL_W_P-1:0] LO_LIM = VAL_W_P'((1 << ARITH_W) - 1);
    localparam logic [VAL_W_P-1:0] HI_LIM = LO_LIM << ARITH_W;

    logic lo_fit;
    logic hi_fit;

    always_comb begin
        lo_fit = (value < LO_LIM);
        hi_fit = !lo_fit && (value < HI_LIM) && (value[ARITH_W-1:0] == '0);
    end

    assign enc = enc_make(lo_fit || hi_fit,
                          lo_fit ? IMM_W'(value[ARITH_W-1:0])
                                 : IMM_W'(value[2*ARITH_W-1:ARITH_W]),
                          hi_fit ? SH_W'(1) : SH_W'(0));

endmodule

// File: rtl/imm_movw_chk.sv
module imm_movw_chk
    import imm_pkg::*;
#(
    parameter int VAL_W_P = VAL_W,
    parameter int SEG_W   = IMM_W
) (
    input  logic [VAL_W_P-1:0] value,
    output enc_t               enc
);
    localparam int NSEG = VAL_W_P / SEG_W;

    logic [NSEG-1:0]  seg_hit;
    logic [SEG_W-1:0] seg_val [NSEG];

    for (genvar k = 0; k < NSEG; k++) begin : g_seg
        localparam logic [VAL_W_P-1:0] KEEP = {{(VAL_W_P-SEG_W){1'b0}}, {SEG_W{1'b1}}} << (k*SEG_W);
        assign seg_hit[k] = ((value & ~KEEP) == '0);
        assign seg_val[k] = value[k*SEG_W +: SEG_W];
    end

    logic             hit;
    logic [SEG_W-1:0] pick_val;
    logic [SH_W-1:0]  pick_idx;

    always_comb begin
        hit      = 1'b0;
        pick_val = '0;
        pick_idx = '0;
        // walk downward so the lowest qualifying halfword wins
        for (int k = NSEG-1; k >= 0; k--) begin
            if (seg_hit[k]) begin
                hit      = 1'b1;
                pick_val = seg_val[k];
                pick_idx = SH_W'(k);
            end
        end
    end

    assign enc = enc_make(hit, IMM_W'(pick_val), pick_idx);

endmodule

// File: rtl/imm_classifier.sv
module imm_classifier
    import imm_pkg::*;
#(
    parameter int VAL_W_P = VAL_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [VAL_W_P-1:0] in_value,
    input  logic [2:0]         in_fmt,
    input  logic               in_size8,
    output logic               out_valid,
    output logic               out_ok,
    output logic [IMM_W-1:0]   out_imm,
    output logic [SH_W-1:0]    out_shift
);
    enc_t e_s7, e_s9, e_u12, e_ar, e_mw;
    enc_t sel;
    enc_t res_q;
    logic vld_q;

    imm_offset_chk #(.VAL_W_P(VAL_W_P)) u_off (
        .value(in_value), .size8(in_size8),
        .enc_s7(e_s7), .enc_s9(e_s9), .enc_u12(e_u12)
    );

    imm_arith_chk #(.VAL_W_P(VAL_W_P)) u_ar (
        .value(in_value), .enc(e_ar)
    );

    imm_movw_chk #(.VAL_W_P(VAL_W_P)) u_mw (
        .value(in_value), .enc(e_mw)
    );

    always_comb begin
        unique case (in_fmt)
            FMT_S7:    sel = e_s7;
            FMT_S9:    sel = e_s9;
            FMT_U12:   sel = e_u12;
            FMT_ARITH: sel = e_ar;
            FMT_MOVW:  sel = e_mw;
            default:   sel = enc_reject();
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            res_q <= enc_reject();
        end else begin
            vld_q <= in_valid;
            if (in_valid) res_q <= sel;
        end
    end

    assign out_valid = vld_q;
    assign out_ok    = res_q.ok;
    assign out_imm   = res_q.imm;
    assign out_shift = res_q.sh;

    assert_valid_R9: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    assert_idle_R9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(out_imm) && $stable(out_ok)));
    assert_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ok) |-> (out_imm == '0 && out_shift == '0));
    assert_unk_R8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_fmt > 3'd4) |=> !out_ok);
    assert_s9_R2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_fmt == FMT_S9 && in_value[VAL_W_P-1:8] == '0) |=> out_ok);
    assert_align_R7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (in_fmt == FMT_S7 || in_fmt == FMT_U12) && in_value[1:0] != 2'b00)
        |=> !out_ok);
    assert_ashift_R5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_fmt == FMT_ARITH && in_value[11:0] != '0 && in_value >= VAL_W_P'(12'hFFF))
        |=> !out_ok);
    assert_movw_R6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_fmt == FMT_MOVW) |=>
        (out_ok == ($past(in_value) == (VAL_W_P'(out_imm) << (16 * out_shift)))));

endmodule

// File: tb/imm_classifier_tb.sv
`timescale 1ns/1ps
module imm_classifier_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [63:0] in_value = '0;
    logic [2:0]  in_fmt = '0;
    logic        in_size8 = 1'b0;
    logic        out_valid;
    logic        out_ok;
    logic [15:0] out_imm;
    logic [1:0]  out_shift;

    int n_tests = 0;
    int n_fail  = 0;

    logic        exp_valid = 1'b0;
    logic        exp_ok    = 1'b0;
    logic [15:0] exp_imm   = '0;
    logic [1:0]  exp_sh    = '0;
    string       exp_tag   = "R10";

    always #2.5 clk = ~clk;

    imm_classifier u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_value(in_value),
        .in_fmt(in_fmt), .in_size8(in_size8), .out_valid(out_valid),
        .out_ok(out_ok), .out_imm(out_imm), .out_shift(out_shift)
    );

    task automatic model(input longint v, input int f, input bit s8,
                         output logic ok, output logic [15:0] imm, output logic [1:0] sh);
        longint      u8 = s8 ? 8 : 4;
        logic [63:0] uv = v;
        ok = 0; imm = 0; sh = 0;
        case (f)
            0: if (v % u8 == 0 && v >= -64*u8 && v <= 63*u8) begin ok = 1; imm = 16'((v / u8) & 'h7f); end
            1: if (v >= -256 && v <= 255) begin ok = 1; imm = 16'(v & 'h1ff); end
            2: if (v % u8 == 0 && v >= 0 && v <= 4095*u8) begin ok = 1; imm = 16'(v / u8); end
            3: if (uv < 64'hFFF) begin ok = 1; imm = uv[15:0]; end
               else if (uv < 64'hFFF000 && uv[11:0] == 0) begin ok = 1; imm = 16'(uv >> 12); sh = 1; end
            4: for (int k = 0; k < 4; k++) begin
                   if (!ok && ((uv & ~(64'hFFFF << (16*k))) == 0)) begin
                       ok = 1; imm = 16'(uv >> (16*k)); sh = 2'(k);
                   end
               end
            default: ok = 0;
        endcase
    endtask

    task automatic check_prev();
        n_tests++;
        if (out_valid !== exp_valid || out_ok !== exp_ok || out_imm !== exp_imm || out_shift !== exp_sh) begin
            n_fail++;
            $display("FAIL %s: got v=%0b ok=%0b imm=%h sh=%0d, expected v=%0b ok=%0b imm=%h sh=%0d",
                     exp_tag, out_valid, out_ok, out_imm, out_shift,
                     exp_valid, exp_ok, exp_imm, exp_sh);
        end
    endtask

    task automatic send(input longint v, input int f, input bit s8, input string tag);
        logic ok; logic [15:0] imm; logic [1:0] sh;
        @(negedge clk);
        check_prev();
        in_valid = 1; in_value = v; in_fmt = 3'(f); in_size8 = s8;
        model(v, f, s8, ok, imm, sh);
        exp_valid = 1; exp_ok = ok; exp_imm = imm; exp_sh = sh; exp_tag = tag;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check_prev();
            in_valid = 0;
            in_value = 64'hDEAD_BEEF_0000_1234;
            exp_valid = 0; exp_tag = "R9";
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        check_prev();
        rst = 1; in_valid = 0;
        exp_valid = 0; exp_ok = 0; exp_imm = 0; exp_sh = 0; exp_tag = "R10";
        @(negedge clk);
        check_prev();
        rst = 0;
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog: got running, expected finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 scaled signed 7-bit, both units
        send(504, 0, 1, "R1");  send(-512, 0, 1, "R1"); send(512, 0, 1, "R1");
        send(-520, 0, 1, "R1"); send(252, 0, 0, "R1");  send(-256, 0, 0, "R1");
        send(256, 0, 0, "R1");  send(-4, 0, 0, "R1");
        // R7 misalignment
        send(12, 0, 1, "R7"); send(6, 0, 0, "R7"); send(4098, 2, 0, "R7"); send(20, 2, 1, "R7");
        idle(2);
        // R2 signed 9-bit
        send(255, 1, 0, "R2"); send(-256, 1, 1, "R2"); send(256, 1, 0, "R2");
        send(-257, 1, 0, "R2"); send(-1, 1, 1, "R2"); send(3, 1, 1, "R2");
        // R3 scaled unsigned 12-bit
        send(32760, 2, 1, "R3"); send(32768, 2, 1, "R3"); send(-8, 2, 1, "R3");
        send(0, 2, 1, "R3");     send(16380, 2, 0, "R3"); send(16384, 2, 0, "R3");
        idle(1);
        // R4 / R5 arithmetic
        send(0, 3, 0, "R4"); send('hFFE, 3, 0, "R4"); send('hFFF, 3, 0, "R4"); send(-1, 3, 0, "R4");
        send('h1000, 3, 0, "R5"); send('hFFE000, 3, 1, "R5"); send('hFFF000, 3, 0, "R5");
        send('h1001, 3, 0, "R5"); send('h1000000, 3, 0, "R5");
        // R6 move-wide
        send(0, 4, 0, "R6"); send('hFFFF, 4, 0, "R6"); send('h10000, 4, 0, "R6");
        send('hABCD00000000, 4, 0, "R6"); send(longint'(64'h8000_0000_0000_0000), 4, 0, "R6");
        send('h10001, 4, 0, "R6"); send(-1, 4, 0, "R6");
        // R8 unknown codes
        send(0, 5, 0, "R8"); send(4, 6, 1, "R8"); send('h10, 7, 0, "R8");
        send(8, 0, 1, "R9"); idle(3); send(0, 7, 0, "R8"); idle(1);
        send('h30000, 4, 0, "R9");
        do_reset();
        idle(2);
        send(-64, 0, 0, "R1");
        idle(1);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule